// File: doc/BRIEF.md
# Quad-Rate Four-Beat Burst SRAM Core

This block is a synthesizable memory model with independent read and write data ports. Every access moves four words. Commands and a base address are registered on the rising edge of K. Write words are taken on alternating K and K# rising edges. Read words come back on alternating K and K# rising edges after a fixed delay. A parameter selects a delay of two or of two and a half K periods.

K and K# are modelled as the two halves of one clock running at twice the K rate. An internal phase flag marks the K half, and the block brings it out so the surrounding logic can align to it. The first rising edge after reset is a K edge. A read and a write may be accepted on the same K edge. A request of the same type on the very next K edge is dropped. The read port has a data bus plus a drive-enable flag, which stands in for high impedance. Each word of a burst uses the base address extended by a two-bit beat index.

Top module: `qdr_burst4_sram`

## Requirements
- R1: While reset is held, and right after it, `rdata_oe` is 0, `rdata` is 0 and `k_phase` is 1. The first rising edge after reset is released is a K edge, and `k_phase` toggles on every edge after that.
- R2: Requests are sampled only on K edges. A request that is low only on a K# edge has no effect.
- R3: A write accepted on edge e0 (a K edge) stores `wdata` as sampled on edges e0+2, e0+3, e0+4 and e0+5. Those four words go to beat indices 0, 1, 2 and 3 in that order.
- R4: With LAT_HALF=0, a read accepted on edge e0 drives its four words on edges e0+4 to e0+7, in beat order 0 to 3, with `rdata_oe` at 1.
- R5: With LAT_HALF=1, a read accepted on edge e0 drives its four words on edges e0+5 to e0+8, in beat order 0 to 3.
- R6: A read request on the K edge right after an accepted read is ignored, so no extra burst appears.
- R7: A write request on the K edge right after an accepted write is ignored, so the array keeps its previous contents.
- R8: Reads accepted on every second K edge give an unbroken run of read words, and writes accepted at that spacing all take effect.
- R9: A read and a write may be accepted on the same K edge. Each read word returns the array contents before any write word captured on the same edge, and it includes every write word captured on an earlier edge.
- R10: On any edge that carries no read word, `rdata_oe` is 0 and `rdata` is 0.
- R11: The array location of a beat is {base address, beat index}, with the beat index in the two least significant bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Double-rate clock; its edges alternate between K and K# |
| rst_n | input | 1 | Synchronous reset, active low |
| rd_req_n | input | 1 | Read request, active low, sampled on K edges |
| wr_req_n | input | 1 | Write request, active low, sampled on K edges |
| addr | input | BASE_W | Burst base address, sampled with the request |
| wdata | input | DATA_W | Write word, sampled on each write beat edge |
| k_phase | output | 1 | 1 when the next rising edge is a K edge |
| rdata | output | DATA_W | Read word; 0 when not driven |
| rdata_oe | output | 1 | Read drive enable, standing in for high impedance |

## Verification
The bench aims at the request-spacing rule. It issues reads and writes on consecutive K edges, and a design that did not drop the second request would show an extra burst on the output or overwrite stored words. A request held low only over a K# edge tests the sampling phase; sampling on both edges would start a stray burst. Two instances run side by side, one per latency setting, so a latency off by a half cycle moves every word into a slot where another is expected. A write issued one K edge after a read to the same base lands its first word on the edge where the faster instance reads that word, which tests whether the read sees the old contents or the new.

// File: rtl/qdr_pkg.sv
package qdr_pkg;

    typedef enum logic {
        PH_KBAR = 1'b0,
        PH_K    = 1'b1
    } phase_e;

    localparam int unsigned BEATS    = 4;
    localparam int unsigned BEAT_W   = 2;

endpackage

// File: rtl/qdr_cmd_decode.sv
module qdr_cmd_decode
    import qdr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rd_req_n,
    input  logic wr_req_n,
    output logic k_edge_o,
    output logic rd_acc_o,
    output logic wr_acc_o
);

    typedef struct packed {
        phase_e phase;
        logic   rd_last;
        logic   wr_last;
    } dec_t;

    dec_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        k_edge_o = (st_q.phase == PH_K);
        rd_acc_o = k_edge_o && !rd_req_n && !st_q.rd_last;
        wr_acc_o = k_edge_o && !wr_req_n && !st_q.wr_last;

        st_d.phase = k_edge_o ? PH_KBAR : PH_K;
        if (k_edge_o) begin
            st_d.rd_last = rd_acc_o;
            st_d.wr_last = wr_acc_o;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_K, rd_last: 1'b0, wr_last: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    AST_RD_NO_B2B: assert property (@(posedge clk) disable iff (!rst_n)
        rd_acc_o |=> ##1 !rd_acc_o);   // R6
    AST_WR_NO_B2B: assert property (@(posedge clk) disable iff (!rst_n)
        wr_acc_o |=> ##1 !wr_acc_o);   // R7
    AST_ACC_AFTER_KBAR: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_acc_o || wr_acc_o) |-> !$past(k_edge_o)); // R2

endmodule

// File: rtl/qdr_burst_seq.sv
module qdr_burst_seq
    import qdr_pkg::*;
#(
    parameter int unsigned BASE_W = 6,
    parameter int unsigned LEAD   = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start_i,
    input  logic [BASE_W-1:0]         base_i,
    output logic                      beat_vld_o,
    output logic [BASE_W+BEAT_W-1:0]  beat_addr_o
);

    localparam int unsigned LAST_BEAT = BEATS - 1;

    typedef struct packed {
        logic [LEAD-1:0]             vld;
        logic [LEAD-1:0][BASE_W-1:0] base;
        logic                        act;
        logic [BEAT_W-1:0]           beat;
        logic [BASE_W-1:0]           cur;
    } seq_t;

    seq_t s_d, s_q;
    logic head;

    assign head = s_q.vld[LEAD-1];

    always_comb begin
        s_d         = s_q;
        beat_vld_o  = 1'b0;
        beat_addr_o = '0;

        s_d.vld[0]  = start_i;
        s_d.base[0] = base_i;
        for (int i = 1; i < int'(LEAD); i++) begin
            s_d.vld[i]  = s_q.vld[i-1];
            s_d.base[i] = s_q.base[i-1];
        end

        if (head) begin
            beat_vld_o  = 1'b1;
            beat_addr_o = {s_q.base[LEAD-1], {BEAT_W{1'b0}}};
            s_d.act     = 1'b1;
            s_d.beat    = BEAT_W'(1);
            s_d.cur     = s_q.base[LEAD-1];
        end else if (s_q.act) begin
            beat_vld_o  = 1'b1;
            beat_addr_o = {s_q.cur, s_q.beat};
            s_d.beat    = s_q.beat + BEAT_W'(1);
            s_d.act     = (s_q.beat != BEAT_W'(LAST_BEAT));
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    AST_SEQ_CONTINUES: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_vld_o && !head) |-> $past(beat_vld_o));   // R11
    AST_SEQ_FIRST_BEAT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        head |-> (beat_addr_o[BEAT_W-1:0] == '0));     // R11

endmodule

// File: rtl/qdr_mem_array.sv
module qdr_mem_array #(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DATA_W = 18
) (
    input  logic              clk,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] waddr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [ADDR_W-1:0] raddr_i,
    output logic [DATA_W-1:0] rdata_o
);

    localparam int unsigned DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we_i) begin
            mem_q[waddr_i] <= wdata_i;
        end
    end

    assign rdata_o = mem_q[raddr_i];

endmodule

// File: rtl/qdr_burst4_sram.sv
module qdr_burst4_sram
    import qdr_pkg::*;
#(
    parameter int unsigned BASE_W   = 6,
    parameter int unsigned DATA_W   = 18,
    parameter int unsigned LAT_HALF = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_req_n,
    input  logic              wr_req_n,
    input  logic [BASE_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              k_phase,
    output logic [DATA_W-1:0] rdata,
    output logic              rdata_oe
);

    localparam int unsigned AW      = BASE_W + BEAT_W;
    localparam int unsigned WR_LEAD = 2;
    localparam int unsigned RD_LEAD = 4 + ((LAT_HALF != 0) ? 1 : 0);

    typedef struct packed {
        logic              oe;
        logic [DATA_W-1:0] data;
    } out_t;

    logic          k_edge, rd_acc, wr_acc;
    logic          wr_vld, rd_vld;
    logic [AW-1:0] wr_addr, rd_addr;
    logic [DATA_W-1:0] arr_rdata;
    out_t          o_d, o_q;

    qdr_cmd_decode u_dec (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_req_n (rd_req_n),
        .wr_req_n (wr_req_n),
        .k_edge_o (k_edge),
        .rd_acc_o (rd_acc),
        .wr_acc_o (wr_acc)
    );

    qdr_burst_seq #(.BASE_W(BASE_W), .LEAD(WR_LEAD)) u_wr_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (wr_acc),
        .base_i      (addr),
        .beat_vld_o  (wr_vld),
        .beat_addr_o (wr_addr)
    );

    qdr_burst_seq #(.BASE_W(BASE_W), .LEAD(RD_LEAD)) u_rd_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (rd_acc),
        .base_i      (addr),
        .beat_vld_o  (rd_vld),
        .beat_addr_o (rd_addr)
    );

    qdr_mem_array #(.ADDR_W(AW), .DATA_W(DATA_W)) u_arr (
        .clk     (clk),
        .we_i    (wr_vld),
        .waddr_i (wr_addr),
        .wdata_i (wdata),
        .raddr_i (rd_addr),
        .rdata_o (arr_rdata)
    );

    always_comb begin
        o_d.oe   = rd_vld;
        o_d.data = rd_vld ? arr_rdata : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            o_q <= '0;
        end else begin
            o_q <= o_d;
        end
    end

    assign k_phase  = k_edge;
    assign rdata    = o_q.data;
    assign rdata_oe = o_q.oe;

    AST_OE_OFF_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> !rdata_oe);                          // R1
    AST_OE_FOUR_BEATS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rdata_oe) |=> rdata_oe ##1 rdata_oe ##1 rdata_oe); // R4
    AST_IDLE_BUS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !rdata_oe |-> (rdata == '0));                           // R10
    AST_PHASE_ALTERNATES: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (k_phase != $past(k_phase)));          // R1

endmodule

// File: tb/test_qdr_burst4_sram.sv
module test_qdr_burst4_sram;
    localparam int BW = 6;
    localparam int DW = 18;
    localparam int AW = BW + 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rd_n = 1'b1;
    logic          wr_n = 1'b1;
    logic [BW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic          kp20, kp25, oe20, oe25;
    logic [DW-1:0] rd20, rd25;

    always #2 clk = ~clk;

    qdr_burst4_sram #(.BASE_W(BW), .DATA_W(DW), .LAT_HALF(0)) i_qdr_burst4_sram (
        .clk(clk), .rst_n(rst_n), .rd_req_n(rd_n), .wr_req_n(wr_n), .addr(addr),
        .wdata(wdata), .k_phase(kp20), .rdata(rd20), .rdata_oe(oe20));

    qdr_burst4_sram #(.BASE_W(BW), .DATA_W(DW), .LAT_HALF(1)) i_qdr_burst4_sram_l25 (
        .clk(clk), .rst_n(rst_n), .rd_req_n(rd_n), .wr_req_n(wr_n), .addr(addr),
        .wdata(wdata), .k_phase(kp25), .rdata(rd25), .rdata_oe(oe25));

    typedef struct { int due; logic [AW-1:0] a; } rd_item_t;

    int errors = 0;
    int checks = 0;
    int ecnt = 0;
    bit running = 0;
    int last_rd = -10;
    int last_wr = -10;
    logic [DW-1:0] ref_mem [0:(1<<AW)-1];
    rd_item_t q20[$];
    rd_item_t q25[$];
    logic [DW-1:0] wd_at[int];
    logic [AW-1:0] wa_at[int];

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Monitor: compare read words, then commit write words captured on this edge
    always begin
        rd_item_t it;
        int cur;
        @(posedge clk);
        #1;
        if (running) begin
            cur = ecnt;
            if (q20.size() > 0 && q20[0].due == cur) begin
                it = q20.pop_front();
                chk("R4", 32'(oe20), 32'd1, "oe lat2.0");
                chk("R4", 32'(rd20), 32'(ref_mem[it.a]), "data lat2.0");
            end else begin
                chk("R10", 32'(oe20), 32'd0, "idle oe lat2.0");
                chk("R10", 32'(rd20), 32'd0, "idle bus lat2.0");
            end
            if (q25.size() > 0 && q25[0].due == cur) begin
                it = q25.pop_front();
                chk("R5", 32'(oe25), 32'd1, "oe lat2.5");
                chk("R5", 32'(rd25), 32'(ref_mem[it.a]), "data lat2.5");
            end else begin
                chk("R10", 32'(oe25), 32'd0, "idle oe lat2.5");
                chk("R10", 32'(rd25), 32'd0, "idle bus lat2.5");
            end
            if (wa_at.exists(cur)) begin
                ref_mem[wa_at[cur]] = wd_at[cur];
                wa_at.delete(cur);
                wd_at.delete(cur);
            end
            chk("R1", 32'(kp20), 32'(((cur + 1) % 2) == 0), "phase");
            ecnt = ecnt + 1;
        end
    end

    // Write data driver: planned words on their edges, noise elsewhere
    always @(negedge clk) begin
        if (running) begin
            if (wd_at.exists(ecnt)) wdata = wd_at[ecnt];
            else                    wdata = DW'($urandom);
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic to_k_neg();
        @(negedge clk);
        while ((ecnt % 2) != 0) @(negedge clk);
    endtask

    task automatic issue(input bit rd, input bit wr, input logic [BW-1:0] b, input logic [DW-1:0] seed);
        int e0;
        to_k_neg();
        e0 = ecnt;
        rd_n = !rd;
        wr_n = !wr;
        addr = b;
        if (rd && e0 != last_rd + 2) begin
            last_rd = e0;
            for (int i = 0; i < 4; i++) begin
                q20.push_back('{due: e0 + 4 + i, a: {b, 2'(i)}});
                q25.push_back('{due: e0 + 5 + i, a: {b, 2'(i)}});
            end
        end
        if (wr && e0 != last_wr + 2) begin
            last_wr = e0;
            for (int i = 0; i < 4; i++) begin
                wa_at[e0 + 2 + i] = {b, 2'(i)};
                wd_at[e0 + 2 + i] = seed + DW'(i * 7);
            end
        end
        @(negedge clk);
        rd_n = 1'b1;
        wr_n = 1'b1;
        addr = BW'($urandom);
    endtask

    task automatic kbar_only_req(input logic [BW-1:0] b);
        to_k_neg();
        @(negedge clk);
        rd_n = 1'b0;
        wr_n = 1'b0;
        addr = b;
        @(negedge clk);
        rd_n = 1'b1;
        wr_n = 1'b1;
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        // R1: state while reset is held
        chk("R1", 32'(oe20), 32'd0, "oe in reset");
        chk("R1", 32'(rd20), 32'd0, "bus in reset");
        chk("R1", 32'(oe25), 32'd0, "oe in reset lat2.5");
        chk("R1", 32'(kp20), 32'd1, "k_phase in reset");
        rst_n = 1'b1;
        running = 1;

        // R3, R11: fill several bursts, spaced one K edge apart (R8)
        issue(0, 1, 6'd3,  18'h01000); idle(2);
        issue(0, 1, 6'd4,  18'h02000); idle(2);
        issue(0, 1, 6'd5,  18'h03000); idle(2);
        issue(0, 1, 6'd10, 18'h04000); idle(2);
        issue(0, 1, 6'd21, 18'h05000); idle(2);
        issue(0, 1, 6'd20, 18'h06000); idle(8);

        // R3, R4, R5, R11: read back one burst
        issue(1, 0, 6'd3, '0); idle(12);

        // R6: second read on the next K edge is dropped
        issue(1, 0, 6'd4, '0);
        issue(1, 0, 6'd5, '0); idle(12);

        // R7: second write on the next K edge is dropped; read both bases
        issue(0, 1, 6'd5, 18'h07000);
        issue(0, 1, 6'd4, 18'h3FF00); idle(8);
        issue(1, 0, 6'd4, '0); idle(2);
        issue(1, 0, 6'd5, '0); idle(12);

        // R2: requests low only across a K# edge
        kbar_only_req(6'd10); idle(12);
        issue(1, 0, 6'd10, '0); idle(12);

        // R8: reads on every second K edge run back to back
        issue(1, 0, 6'd3, '0); idle(2);
        issue(1, 0, 6'd10, '0); idle(2);
        issue(1, 0, 6'd21, '0); idle(12);

        // R9: read and write on the same K edge, same base
        issue(1, 1, 6'd20, 18'h08000); idle(12);
        // R9: write one K edge after a read of the same base
        issue(1, 0, 6'd21, '0);
        issue(0, 1, 6'd21, 18'h09000); idle(12);
        issue(1, 0, 6'd21, '0); idle(16);

        chk("R4", 32'(q20.size()), 32'd0, "reads left over lat2.0");
        chk("R5", 32'(q25.size()), 32'd0, "reads left over lat2.5");
        summary();
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL R1 watchdog: actual=running expected=finished");
        summary();
        $finish;
    end

endmodule